// File: doc/BRIEF.md
# Addressed SPI Control-Port Slave

This block is the host-facing serial control port of a processor core. A host frames each transaction by pulling a select line low, runs a serial clock that idles low, and sends data most significant bit first. The first byte of every frame is a header: a 7-bit device address in the upper bits and a direction flag in bit 0, where 0 means write and 1 means read. The port compares the address against a parameter, which defaults to zero. A write header for address zero is therefore the byte 0x00.

After a matching write header, every further byte in the same frame goes to the core as a one-cycle `rx_valid` strobe. The strobe follows the falling edge of the byte's eighth serial clock, not the rising edge. A frame may carry any number of such bytes. The core signals that it has a byte for the host by raising `tx_valid`, and the port answers with an active-low request line. A read header moves that byte out on the serial output, most significant bit first. The port then acknowledges the core with a one-cycle `tx_taken` pulse and releases the request line.

All pins are sampled into the system clock domain through two-flop synchronizers, and serial clock edges are found from the synchronized copy. The system clock therefore has to run several times faster than the serial clock.

Top module: `ctl_port_slave`

## Requirements
- R1: After reset `rx_valid` and `tx_taken` are 0, `irq_n` is 1 and `sd_out` is 0.
- R2: After the write header (address bits [7:1] equal to `DEV_ADDR`, bit 0 = 0), each following byte, assembled MSB first, appears on `rx_byte` with `rx_valid` high for exactly one clock.
- R3: A data byte's strobe occurs only after the falling edge of its eighth serial clock; after the eighth rising edge alone no strobe has appeared.
- R4: Any number of data bytes may follow a single write header within one select frame, each producing its own strobe in order.
- R5: A header whose address bits differ from `DEV_ADDR` causes every remaining byte of that frame to be ignored, with no strobe.
- R6: Header state does not carry over: deselecting ends the transaction, and the first byte of the next frame is decoded as a header again.
- R7: Raising `sel_n` in the middle of a byte discards the partial byte and clears the bit count and header state, so the next frame decodes correctly.
- R8: `irq_n` goes low within two clocks of `tx_valid` rising and returns high once the byte has been shifted out, staying high until `tx_valid` drops and rises again.
- R9: After a read header (bit 0 = 1, address matching), the next byte's serial clocks shift `tx_byte` out on `sd_out` MSB first, each bit valid before its rising edge. After that byte's eighth falling edge, `tx_taken` pulses for one clock.
- R10: Outside a read frame `sd_out` is 0, further bytes in a read frame shift out as 0x00, and bytes received during a read frame produce no strobe.
- R11: A read frame while `tx_valid` is low shifts out 0x00 and does not pulse `tx_taken`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Frame select from host, active low |
| sclk_in | input | 1 | Serial clock from host, idles low |
| sd_in | input | 1 | Serial data from host |
| sd_out | output | 1 | Serial data to host, 0 when not reading |
| irq_n | output | 1 | Active-low request: core has a byte for the host |
| rx_valid | output | 1 | One-cycle strobe for a received data byte |
| rx_byte | output | 8 | Received data byte |
| tx_valid | input | 1 | Core has a byte waiting for the host |
| tx_byte | input | 8 | Byte to send to the host |
| tx_taken | output | 1 | One-cycle pulse once the byte has been shifted out |

## Verification
Some rules can be checked on every cycle, and the assertions cover those. The strobe must follow a synchronized falling serial edge and must last one clock. The skip state must stay silent. Deselecting must clear the bit count and header phase. The request line must be released whenever the core has nothing valid. The acknowledge must be a single pulse. Other behaviour depends on whole byte sequences, and only the directed scenarios can show it: the received byte values and their order, MSB-first output on the serial line, the effect of a mismatched header or an aborted byte on later frames, and what happens when a read finds nothing queued.

// File: rtl/ctl_port_pkg.sv
// Shared types for the serial control-port slave.
package ctl_port_pkg;
    // Transaction phase inside one select frame.
    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,   // waiting for the address/direction byte
        PH_WR   = 2'd1,   // header matched, direction write
        PH_RD   = 2'd2,   // header matched, direction read
        PH_SKIP = 2'd3    // header mismatched, ignore rest of frame
    } phase_t;
endpackage

// File: rtl/ctl_sync_bank.sv
// Multi-stage synchronizer for a bank of asynchronous pins.
// Assumes each pin is slow relative to clk (held several clk cycles),
// so per-bit synchronization without a handshake is sufficient.
module ctl_sync_bank #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] stg [STAGES];

    // Shift every pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/ctl_rx_frame.sv
// Receive side: serial clock edge detection, MSB-first byte assembly,
// header decode and write-byte strobing. Assumes synchronized inputs;
// data is sampled on rising edges, bytes end on the eighth falling edge.
module ctl_rx_frame
    import ctl_port_pkg::*;
#(
    parameter int                ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] DEV_ADDR = '0,
    localparam int               BYTE_W   = ADDR_W + 1,
    localparam int               CNT_W    = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,      // synchronized select, 1 = idle
    input  logic              sclk_s,
    input  logic              sd_s,
    output logic              sclk_fall,
    output logic              byte_end,
    output phase_t            phase,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte
);
    logic              sclk_d;
    logic              sclk_rise;
    logic [BYTE_W-1:0] shreg;

    // Remember last synchronized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_d & ~sel_s;
    assign sclk_fall = ~sclk_s & sclk_d & ~sel_s;
    assign byte_end  = sclk_fall && (bit_cnt == CNT_W'(BYTE_W));

    // Bit counting, byte assembly, header decode and write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            phase    <= PH_HDR;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (sel_s) begin
                bit_cnt <= '0;
                phase   <= PH_HDR;
            end else begin
                if (sclk_rise && bit_cnt != CNT_W'(BYTE_W)) begin
                    shreg   <= {shreg[BYTE_W-2:0], sd_s};
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
                if (byte_end) begin
                    bit_cnt <= '0;
                    case (phase)
                        PH_HDR: begin
                            if (shreg[BYTE_W-1:1] != DEV_ADDR) phase <= PH_SKIP;
                            else if (shreg[0])                 phase <= PH_RD;
                            else                               phase <= PH_WR;
                        end
                        PH_WR: begin
                            rx_valid <= 1'b1;
                            rx_byte  <= shreg;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/ctl_tx_path.sv
// Transmit side: loads the core's byte when a read header is decoded,
// shifts it out MSB first on falling serial edges, acknowledges the core
// and drives the active-low request line. One queued byte per read frame.
module ctl_tx_path
    import ctl_port_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,
    input  logic              sclk_fall,
    input  logic              byte_end,
    input  phase_t            phase,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sd_out,
    output logic              tx_taken,
    output logic              irq_n
);
    logic [BYTE_W-1:0] sh_tx;
    logic              loaded;
    logic              done;
    phase_t            phase_d;
    logic              rd_enter;

    assign rd_enter = (phase == PH_RD) && (phase_d != PH_RD);

    // Load, shift and acknowledge the outgoing byte; track request state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_tx    <= '0;
            loaded   <= 1'b0;
            done     <= 1'b0;
            tx_taken <= 1'b0;
            irq_n    <= 1'b1;
            phase_d  <= PH_HDR;
        end else begin
            tx_taken <= 1'b0;
            phase_d  <= phase;
            irq_n    <= !(tx_valid && !done);
            if (!tx_valid) done <= 1'b0;
            if (sel_s) begin
                sh_tx  <= '0;
                loaded <= 1'b0;
            end else if (rd_enter) begin
                if (tx_valid && !done) begin
                    sh_tx  <= tx_byte;
                    loaded <= 1'b1;
                end else begin
                    sh_tx <= '0;
                end
            end else if (phase == PH_RD && byte_end) begin
                if (loaded) begin
                    tx_taken <= 1'b1;
                    done     <= 1'b1;
                end
                loaded <= 1'b0;
                sh_tx  <= '0;
            end else if (phase == PH_RD && sclk_fall) begin
                sh_tx <= {sh_tx[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign sd_out = sh_tx[BYTE_W-1] & (phase == PH_RD);
endmodule

// File: rtl/ctl_port_slave.sv
// Top of the addressed serial control-port slave. Synchronizes the host
// pins, then splits into a receive path (header decode, write strobes)
// and a transmit path (read-out, acknowledge, request line).
// Assumes clk runs well above the serial clock (4x or more per half period).
module ctl_port_slave
    import ctl_port_pkg::*;
#(
    parameter int                ADDR_W      = 7,
    parameter logic [ADDR_W-1:0] DEV_ADDR    = '0,
    parameter int                SYNC_STAGES = 2,
    localparam int               BYTE_W      = ADDR_W + 1,
    localparam int               CNT_W       = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sclk_in,
    input  logic              sd_in,
    output logic              sd_out,
    output logic              irq_n,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_taken
);
    logic [2:0]       pins_s;
    logic             sel_s;
    logic             sclk_s;
    logic             sd_s;
    logic             sclk_fall;
    logic             byte_end;
    phase_t           phase;
    logic [CNT_W-1:0] bit_cnt;

    ctl_sync_bank #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sel_n, sclk_in, sd_in}),
        .sync_out (pins_s)
    );

    assign sel_s  = pins_s[2];
    assign sclk_s = pins_s[1];
    assign sd_s   = pins_s[0];

    ctl_rx_frame #(
        .ADDR_W   (ADDR_W),
        .DEV_ADDR (DEV_ADDR)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_s     (sel_s),
        .sclk_s    (sclk_s),
        .sd_s      (sd_s),
        .sclk_fall (sclk_fall),
        .byte_end  (byte_end),
        .phase     (phase),
        .bit_cnt   (bit_cnt),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte)
    );

    ctl_tx_path #(
        .BYTE_W (BYTE_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_s     (sel_s),
        .sclk_fall (sclk_fall),
        .byte_end  (byte_end),
        .phase     (phase),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .sd_out    (sd_out),
        .tx_taken  (tx_taken),
        .irq_n     (irq_n)
    );
endmodule

// File: rtl/ctl_port_checker.sv
// Cycle-level protocol checks for ctl_port_slave, attached by bind.
module ctl_port_checker
    import ctl_port_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_s,
    input logic             sclk_fall,
    input phase_t           phase,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             rx_valid,
    input logic             tx_valid,
    input logic             tx_taken,
    input logic             irq_n
);
    // R3: a write strobe only follows a detected falling serial edge
    a_r3_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sclk_fall));

    // R2: each write strobe lasts one clock
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5: a mismatched frame stays silent
    a_r5_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP) |-> !rx_valid);

    // R7: deselect clears bit count and header state
    a_r7_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> (bit_cnt == '0 && phase == PH_HDR));

    // R8: request line released when the core holds nothing
    a_r8_irq_released: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |=> irq_n);

    // R9: acknowledge is a single pulse
    a_r9_taken_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_taken |=> !tx_taken);
endmodule

bind ctl_port_slave ctl_port_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_s     (sel_s),
    .sclk_fall (sclk_fall),
    .phase     (phase),
    .bit_cnt   (bit_cnt),
    .rx_valid  (rx_valid),
    .tx_valid  (tx_valid),
    .tx_taken  (tx_taken),
    .irq_n     (irq_n)
);

// File: tb/tb_ctl_port_slave.sv
module tb_ctl_port_slave;
    localparam int HALF = 8;   // clk cycles per serial half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic       sclk_in = 1'b0;
    logic       sd_in = 1'b0;
    logic       sd_out;
    logic       irq_n;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_taken;

    int total = 0;
    int bad = 0;
    int ngot = 0;
    int ntaken = 0;
    logic [7:0] got [0:63];
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    ctl_port_slave dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .sclk_in  (sclk_in),
        .sd_in    (sd_in),
        .sd_out   (sd_out),
        .irq_n    (irq_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte),
        .tx_taken (tx_taken)
    );

    // Record received bytes and acknowledges.
    always @(posedge clk) begin
        if (rx_valid) begin
            if (ngot < 64) got[ngot] <= rx_byte;
            ngot <= ngot + 1;
        end
        if (tx_taken) ntaken <= ntaken + 1;
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_open();
        @(negedge clk);
        sel_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic frame_close();
        wait_clk(HALF);
        sel_n = 1'b1;
        wait_clk(3 * HALF);
    endtask

    // Send nbits of b MSB first; sample sd_out before each rising edge.
    // If hold_high, leave the clock high after the last bit.
    task automatic shift_bits(input logic [7:0] b, input int nbits,
                              input bit hold_high, output logic [7:0] rd);
        rd = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk);
            sd_in = b[i];
            wait_clk(HALF);
            rd[i] = sd_out;
            sclk_in = 1'b1;
            wait_clk(HALF);
            if (!(hold_high && i == 8 - nbits)) sclk_in = 1'b0;
        end
        if (!hold_high) wait_clk(HALF);
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] rd);
        shift_bits(b, 8, 1'b0, rd);
    endtask

    task automatic t_reset();
        check("R1 rx_valid", rx_valid, 0);
        check("R1 tx_taken", tx_taken, 0);
        check("R1 irq_n", irq_n, 1);
        check("R1 sd_out", sd_out, 0);
    endtask

    task automatic t_write_multi();
        logic [7:0] rd;
        logic [7:0] data [4] = '{8'h3C, 8'hA5, 8'hFF, 8'h01};
        int base = ngot;
        frame_open();
        xfer(8'h00, rd);
        for (int k = 0; k < 4; k++) begin
            xfer(data[k], rd);
            check("R10 sd_out low in write frame", rd, 0);
        end
        frame_close();
        check("R4 strobe count", ngot - base, 4);
        for (int k = 0; k < 4; k++) check("R2 byte value", got[base + k], data[k]);
    endtask

    task automatic t_strobe_edge();
        logic [7:0] rd;
        int base = ngot;
        frame_open();
        xfer(8'h00, rd);
        shift_bits(8'h6E, 8, 1'b1, rd);
        wait_clk(HALF);
        check("R3 no strobe after eighth rise", ngot - base, 0);
        sclk_in = 1'b0;
        wait_clk(HALF);
        check("R3 strobe after eighth fall", ngot - base, 1);
        check("R3 byte value", got[base], 8'h6E);
        frame_close();
    endtask

    task automatic t_mismatch();
        logic [7:0] rd;
        int base = ngot;
        frame_open();
        xfer(8'h02, rd);          // address 1, write
        xfer(8'h11, rd);
        xfer(8'h22, rd);
        frame_close();
        check("R5 mismatched header ignored", ngot - base, 0);
    endtask

    task automatic t_header_per_frame();
        logic [7:0] rd;
        int base = ngot;
        frame_open();
        xfer(8'h00, rd);
        xfer(8'h10, rd);
        frame_close();
        frame_open();
        xfer(8'h80, rd);          // decoded as header: address 0x40
        xfer(8'h20, rd);
        frame_close();
        check("R6 only first frame strobes", ngot - base, 1);
        check("R6 first frame byte", got[base], 8'h10);
    endtask

    task automatic t_abort();
        logic [7:0] rd;
        int base = ngot;
        frame_open();
        xfer(8'h00, rd);
        shift_bits(8'hF0, 4, 1'b0, rd);
        wait_clk(HALF);
        sel_n = 1'b1;
        wait_clk(3 * HALF);
        check("R7 partial byte discarded", ngot - base, 0);
        frame_open();
        xfer(8'h00, rd);
        xfer(8'h99, rd);
        frame_close();
        check("R7 next frame one strobe", ngot - base, 1);
        check("R7 next frame byte", got[base], 8'h99);
    endtask

    task automatic t_read();
        logic [7:0] rd;
        int base_t = ntaken;
        int base_r = ngot;
        @(negedge clk);
        tx_byte  = 8'hB6;
        tx_valid = 1'b1;
        wait_clk(3);
        check("R8 irq_n asserted", irq_n, 0);
        frame_open();
        xfer(8'h01, rd);
        xfer(8'h5A, rd);
        check("R9 shifted byte", rd, 8'hB6);
        check("R9 one acknowledge", ntaken - base_t, 1);
        wait_clk(3);
        check("R8 irq_n released after read", irq_n, 1);
        xfer(8'hC3, rd);
        check("R10 second read byte zero", rd, 0);
        frame_close();
        check("R10 no strobe in read frame", ngot - base_r, 0);
        check("R10 sd_out idle", sd_out, 0);
        check("R8 irq_n stays high", irq_n, 1);
        check("R9 still one acknowledge", ntaken - base_t, 1);
        @(negedge clk);
        tx_valid = 1'b0;
        wait_clk(3);
        check("R8 irq_n high when idle", irq_n, 1);
    endtask

    task automatic t_read_empty();
        logic [7:0] rd;
        int base_t = ntaken;
        frame_open();
        xfer(8'h01, rd);
        xfer(8'h00, rd);
        frame_close();
        check("R11 empty read zero", rd, 0);
        check("R11 no acknowledge", ntaken - base_t, 0);
        check("R11 irq_n high", irq_n, 1);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_write_multi();
        t_strobe_edge();
        t_mismatch();
        t_header_per_frame();
        t_abort();
        t_read();
        t_read_empty();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule